// File: doc/BRIEF.md
# Flash Page Programming Sequencer

This block runs on the host side of a serial in-system programming link after the target has already entered programming mode. For each page it receives a page number and a stream of 16-bit data words. It turns every word into two page-buffer load commands: the low byte first, then the high byte, each tagged with the word's index inside the page. After the last word it sends one page-write command, which carries the page's base word address. It then keeps the link quiet until the write has finished. It finds the end of the write either by counting a fixed number of clocks or by polling the target's ready flag. When asked, it then reads the page back word by word and compares the result against what it loaded.

The link itself is reached through a transaction port. Each command is a 32-bit value of four bytes, with the first byte on the wire in bits 31:24. The command is handed over with a valid/ready handshake. For every command the link returns exactly one response byte, which is the byte shifted in during the fourth transfer. The sequencer keeps at most one command in flight. A compare failure raises a sticky error flag and captures the word address of the first word that failed.

Top module: `flash_page_seq`

## Requirements
- R1: After reset, busy, done, cmdValid, wordReady and errFlag are all low and errAddr is zero.
- R2: A pageStart pulse seen while idle latches pageAddr, pollMode and verifyEn. The block then accepts exactly PAGE_WORDS words on the wordValid/wordReady stream, taking one word per handshake.
- R3: For the word with in-page index i, the block sends {0x40, 0x00, i, data[7:0]} and then {0x48, 0x00, i, data[15:8]}. A high-byte load is never sent unless the low-byte load for the same index came immediately before it.
- R4: After the load pair for index PAGE_WORDS-1, the block sends {0x4C, A[15:8], A[7:0], 0x00}. Here A is the 16-bit zero-extended word address {pageAddr, index 0}.
- R5: In timed mode (pollMode=0), cmdValid stays low for at least WAIT_CYCLES cycles after the cycle in which the page-write response arrives.
- R6: In polling mode (pollMode=1), the block sends {0xF0, 0x00, 0x00, 0x00} after the write. While the last poll response had bit 0 set (busy), every command it sends is another poll.
- R7: With verifyEn set, once the write has completed the block reads every word of the page in index order. Each word takes {0x20, A[15:8], A[7:0], 0x00}, whose response is the low byte, and then {0x28, A[15:8], A[7:0], 0x00}, whose response is the high byte. Here A is that word's 16-bit address. With verifyEn clear, no read is sent.
- R8: A read-back word that differs from the loaded word sets errFlag and loads errAddr with its word address {pageAddr, index}. Once errFlag is set, it and errAddr keep their values until reset, and later mismatches do not change them.
- R9: busy is high from the cycle after an accepted pageStart through the single-cycle done pulse that ends the page. A pageStart pulse while busy is ignored. While busy is low, cmdValid and wordReady stay low.
- R10: While cmdValid is high and cmdReady is low, cmdValid and cmdBytes hold their values. No new command is presented between a handshake and the response to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pageStart | input | 1 | Starts a page when the block is idle |
| pageAddr | input | PAGE_NUM_W | Page number, latched at start |
| pollMode | input | 1 | 1 = poll for write completion, 0 = fixed wait |
| verifyEn | input | 1 | 1 = read back and compare the page after the write |
| wordValid | input | 1 | Stream word available |
| wordReady | output | 1 | Sequencer takes the word in this cycle |
| wordData | input | 16 | Stream word, in index order |
| cmdValid | output | 1 | Command presented to the link |
| cmdReady | input | 1 | Link accepts the command |
| cmdBytes | output | 32 | Four command bytes, first byte in bits 31:24 |
| rspValid | input | 1 | One-cycle response strobe |
| rspByte | input | 8 | Byte returned by the fourth transfer |
| busy | output | 1 | Page in progress |
| done | output | 1 | One-cycle pulse at the end of a page |
| errFlag | output | 1 | Sticky verify-mismatch flag |
| errAddr | output | PAGE_NUM_W+log2(PAGE_WORDS) | Word address of the first mismatch |

## Verification
The bench models the target. The model holds a page buffer and a flash array, stays busy for a set number of cycles after each write, and counts every command that arrives while it is busy. A wait that is short by even one cycle therefore shows up as a busy violation, and also in the measured gap before the first read. The model also checks the index sequence of the loads, so a design that sends the high byte first, skips an index or repeats one is caught, and so is one that writes before the page is full. Verify is tested by corrupting one stored word. A wrong errAddr, a flag that clears, or a second mismatch that overwrites the first address would each be reported. A pageStart injected halfway through a page must not produce a second write, and the pages at number 0 and at the top number exercise the edges of the address field.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    CK_LOADLO,
    CK_LOADHI,
    CK_WRITE,
    CK_POLL,
    CK_READLO,
    CK_READHI
  } cmdKind_t;

  localparam logic [7:0] OP_LOADLO = 8'h40;
  localparam logic [7:0] OP_LOADHI = 8'h48;
  localparam logic [7:0] OP_WRITE  = 8'h4C;
  localparam logic [7:0] OP_POLL   = 8'hF0;
  localparam logic [7:0] OP_READLO = 8'h20;
  localparam logic [7:0] OP_READHI = 8'h28;

  // strobes from control to datapath
  typedef struct packed {
    logic     capStart;
    logic     clrIdx;
    logic     incIdx;
    logic     capWord;
    logic     startWait;
    logic     capReadLo;
    logic     cmpWord;
    cmdKind_t kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pageStart,
  input  logic        pollMode,
  input  logic        verifyEn,
  input  logic        wordValid,
  input  logic        cmdReady,
  input  logic        rspValid,
  input  logic        rspBusy,
  input  logic        lastIdx,
  input  logic        waitDone,
  output logic        wordReady,
  output logic        cmdValid,
  output logic        busy,
  output logic        done,
  output ctrlStrobe_t st
);

  typedef enum logic [2:0] {
    S_IDLE, S_GETWORD, S_ISSUE, S_WAITRSP, S_WAITTIME, S_DONE
  } state_t;

  state_t   stateQ, stateD;
  cmdKind_t kindQ, kindD;
  logic     pollQ, verQ;
  logic     writeOver;

  always_comb begin
    stateD    = stateQ;
    kindD     = kindQ;
    st        = '0;
    st.kind   = kindQ;
    wordReady = 1'b0;
    cmdValid  = 1'b0;
    done      = 1'b0;
    writeOver = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (pageStart) begin
          st.capStart = 1'b1;
          st.clrIdx   = 1'b1;
          stateD      = S_GETWORD;
        end
      end
      S_GETWORD: begin
        wordReady = 1'b1;
        if (wordValid) begin
          st.capWord = 1'b1;
          kindD      = CK_LOADLO;
          stateD     = S_ISSUE;
        end
      end
      S_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) stateD = S_WAITRSP;
      end
      S_WAITRSP: begin
        if (rspValid) begin
          unique case (kindQ)
            CK_LOADLO: begin
              kindD  = CK_LOADHI;
              stateD = S_ISSUE;
            end
            CK_LOADHI: begin
              if (lastIdx) begin
                kindD  = CK_WRITE;
                stateD = S_ISSUE;
              end else begin
                st.incIdx = 1'b1;
                stateD    = S_GETWORD;
              end
            end
            CK_WRITE: begin
              if (pollQ) begin
                kindD  = CK_POLL;
                stateD = S_ISSUE;
              end else begin
                st.startWait = 1'b1;
                stateD       = S_WAITTIME;
              end
            end
            CK_POLL: begin
              if (rspBusy) stateD = S_ISSUE;
              else         writeOver = 1'b1;
            end
            CK_READLO: begin
              st.capReadLo = 1'b1;
              kindD        = CK_READHI;
              stateD       = S_ISSUE;
            end
            CK_READHI: begin
              st.cmpWord = 1'b1;
              if (lastIdx) begin
                stateD = S_DONE;
              end else begin
                st.incIdx = 1'b1;
                kindD     = CK_READLO;
                stateD    = S_ISSUE;
              end
            end
            default: stateD = S_DONE;
          endcase
        end
      end
      S_WAITTIME: begin
        if (waitDone) writeOver = 1'b1;
      end
      S_DONE: begin
        done   = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase

    if (writeOver) begin
      if (verQ) begin
        st.clrIdx = 1'b1;
        kindD     = CK_READLO;
        stateD    = S_ISSUE;
      end else begin
        stateD = S_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      kindQ  <= CK_LOADLO;
      pollQ  <= 1'b0;
      verQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
      if (st.capStart) begin
        pollQ <= pollMode;
        verQ  <= verifyEn;
      end
    end
  end

  assign busy = (stateQ != S_IDLE);

endmodule

// File: rtl/fps_dpath.sv
module fps_dpath
  import fps_pkg::*;
#(
  parameter int PAGE_WORDS  = 64,
  parameter int PAGE_NUM_W  = 8,
  parameter int WAIT_CYCLES = 1000,
  localparam int IDX_W  = $clog2(PAGE_WORDS),
  localparam int ADDR_W = PAGE_NUM_W + IDX_W,
  localparam int CNT_W  = $clog2(WAIT_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           st,
  input  logic [PAGE_NUM_W-1:0] pageAddr,
  input  logic [15:0]           wordData,
  input  logic [7:0]            rspByte,
  output logic [31:0]           cmdBytes,
  output logic                  lastIdx,
  output logic                  waitDone,
  output logic                  errFlag,
  output logic [ADDR_W-1:0]     errAddr
);

  logic [PAGE_NUM_W-1:0] pageQ;
  logic [IDX_W-1:0]      idxQ;
  logic [15:0]           bufQ [PAGE_WORDS];
  logic [7:0]            readLoQ;
  logic [CNT_W-1:0]      waitQ;
  logic [15:0]           curWord;
  logic [15:0]           wordAddr;
  logic [15:0]           pageBase;
  logic [7:0]            idxByte;

  assign curWord  = bufQ[idxQ];
  assign wordAddr = 16'({pageQ, idxQ});
  assign pageBase = 16'({pageQ, {IDX_W{1'b0}}});
  assign idxByte  = 8'(idxQ);
  assign lastIdx  = (idxQ == IDX_W'(PAGE_WORDS - 1));
  assign waitDone = (waitQ <= CNT_W'(1));

  always_comb begin
    unique case (st.kind)
      CK_LOADLO: cmdBytes = {OP_LOADLO, 8'h00, idxByte, curWord[7:0]};
      CK_LOADHI: cmdBytes = {OP_LOADHI, 8'h00, idxByte, curWord[15:8]};
      CK_WRITE:  cmdBytes = {OP_WRITE, pageBase, 8'h00};
      CK_POLL:   cmdBytes = {OP_POLL, 24'h000000};
      CK_READLO: cmdBytes = {OP_READLO, wordAddr, 8'h00};
      CK_READHI: cmdBytes = {OP_READHI, wordAddr, 8'h00};
      default:   cmdBytes = '0;
    endcase
  end

  // page buffer, no reset needed: each entry is written before it is read
  always_ff @(posedge clk) begin
    if (st.capWord) bufQ[idxQ] <= wordData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ   <= '0;
      idxQ    <= '0;
      readLoQ <= '0;
      waitQ   <= '0;
      errFlag <= 1'b0;
      errAddr <= '0;
    end else begin
      if (st.capStart) pageQ <= pageAddr;
      if (st.clrIdx)      idxQ <= '0;
      else if (st.incIdx) idxQ <= idxQ + IDX_W'(1);
      if (st.capReadLo) readLoQ <= rspByte;
      if (st.startWait)       waitQ <= CNT_W'(WAIT_CYCLES);
      else if (waitQ != '0)   waitQ <= waitQ - CNT_W'(1);
      if (st.cmpWord && !errFlag && ({rspByte, readLoQ} != curWord)) begin
        errFlag <= 1'b1;
        errAddr <= {pageQ, idxQ};
      end
    end
  end

endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import fps_pkg::*;
#(
  parameter int PAGE_WORDS  = 64,
  parameter int PAGE_NUM_W  = 8,
  parameter int WAIT_CYCLES = 1000,
  localparam int IDX_W  = $clog2(PAGE_WORDS),
  localparam int ADDR_W = PAGE_NUM_W + IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pageStart,
  input  logic [PAGE_NUM_W-1:0] pageAddr,
  input  logic                  pollMode,
  input  logic                  verifyEn,
  input  logic                  wordValid,
  output logic                  wordReady,
  input  logic [15:0]           wordData,
  output logic                  cmdValid,
  input  logic                  cmdReady,
  output logic [31:0]           cmdBytes,
  input  logic                  rspValid,
  input  logic [7:0]            rspByte,
  output logic                  busy,
  output logic                  done,
  output logic                  errFlag,
  output logic [ADDR_W-1:0]     errAddr
);

  ctrlStrobe_t st;
  logic        lastIdx;
  logic        waitDone;

  fps_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pageStart (pageStart),
    .pollMode  (pollMode),
    .verifyEn  (verifyEn),
    .wordValid (wordValid),
    .cmdReady  (cmdReady),
    .rspValid  (rspValid),
    .rspBusy   (rspByte[0]),
    .lastIdx   (lastIdx),
    .waitDone  (waitDone),
    .wordReady (wordReady),
    .cmdValid  (cmdValid),
    .busy      (busy),
    .done      (done),
    .st        (st)
  );

  fps_dpath #(
    .PAGE_WORDS  (PAGE_WORDS),
    .PAGE_NUM_W  (PAGE_NUM_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .pageAddr (pageAddr),
    .wordData (wordData),
    .rspByte  (rspByte),
    .cmdBytes (cmdBytes),
    .lastIdx  (lastIdx),
    .waitDone (waitDone),
    .errFlag  (errFlag),
    .errAddr  (errAddr)
  );

endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int WAIT_CYCLES = 1000,
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [31:0]       cmdBytes,
  input logic              rspValid,
  input logic              rspBit0,
  input logic              busy,
  input logic              done,
  input logic              errFlag,
  input logic [ADDR_W-1:0] errAddr
);

  logic [7:0]       lastOp, lastIdxB;
  logic             outstanding, inWait, busySeen;
  logic [CNT_W-1:0] waitCnt;
  logic             hs;

  assign hs = cmdValid && cmdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOp      <= '0;
      lastIdxB    <= '0;
      outstanding <= 1'b0;
      inWait      <= 1'b0;
      busySeen    <= 1'b0;
      waitCnt     <= '0;
    end else begin
      if (hs) begin
        lastOp   <= cmdBytes[31:24];
        lastIdxB <= cmdBytes[15:8];
      end
      if (hs)            outstanding <= 1'b1;
      else if (rspValid) outstanding <= 1'b0;
      if (rspValid && lastOp == OP_WRITE) begin
        inWait  <= 1'b1;
        waitCnt <= '0;
      end else if (hs) begin
        inWait <= 1'b0;
      end else if (inWait && !cmdValid && waitCnt != CNT_W'(WAIT_CYCLES)) begin
        waitCnt <= waitCnt + CNT_W'(1);
      end
      if (rspValid && lastOp == OP_POLL) busySeen <= rspBit0;
    end
  end

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !done);

  a_r3_low_before_high: assert property (@(posedge clk) disable iff (!rstN)
    hs && cmdBytes[31:24] == OP_LOADHI |-> lastOp == OP_LOADLO && lastIdxB == cmdBytes[15:8]);

  a_r5_write_wait: assert property (@(posedge clk) disable iff (!rstN)
    inWait && cmdValid && cmdBytes[31:24] != OP_POLL |-> waitCnt >= CNT_W'(WAIT_CYCLES));

  a_r6_poll_only: assert property (@(posedge clk) disable iff (!rstN)
    busySeen && cmdValid |-> cmdBytes[31:24] == OP_POLL);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag && $stable(errAddr));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid && !wordReady);

  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdBytes));

  a_r10_single: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !cmdValid);

endmodule

bind flash_page_seq fps_checker #(
  .ADDR_W      (ADDR_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wordReady (wordReady),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdBytes  (cmdBytes),
  .rspValid  (rspValid),
  .rspBit0   (rspByte[0]),
  .busy      (busy),
  .done      (done),
  .errFlag   (errFlag),
  .errAddr   (errAddr)
);

// File: tb/tb_flash_page_seq.sv
module tb_flash_page_seq;

  localparam int PW    = 8;
  localparam int PNW   = 8;
  localparam int WC    = 20;
  localparam int IDX_W = $clog2(PW);
  localparam int AW    = PNW + IDX_W;

  logic           clk = 1'b0;
  logic           rstN;
  logic           pageStart;
  logic [PNW-1:0] pageAddr;
  logic           pollMode, verifyEn;
  logic           wordValid, wordReady;
  logic [15:0]    wordData;
  logic           cmdValid, cmdReady;
  logic [31:0]    cmdBytes;
  logic           rspValid;
  logic [7:0]     rspByte;
  logic           busy, done, errFlag;
  logic [AW-1:0]  errAddr;

  always #2 clk = ~clk;

  flash_page_seq #(.PAGE_WORDS(PW), .PAGE_NUM_W(PNW), .WAIT_CYCLES(WC)) dut (.*);

  int checks = 0;
  int errors = 0;

  // target model state
  logic [15:0] flashMem [int];
  logic [7:0]  pbLo [PW];
  logic [7:0]  pbHi [PW];
  int   busyCnt, mBusyLen, mCorrupt, dly;
  logic [7:0] pend, mLastOp;
  int   expIdx;
  bit   expectHi;
  int   ordViol, busyViol, loadCount, writeCount, readCount, pollCount;
  logic [15:0] lastWriteAddr;
  // monitor state
  int   wordsAccepted, doneCycles, gap, gapSeen;
  bit   doneSeen, tracking;
  logic [15:0] pageData [PW];

  function automatic logic [15:0] rdFlash(input int a);
    return flashMem.exists(a) ? flashMem[a] : 16'hFFFF;
  endfunction

  function automatic logic [15:0] baseAddr(input logic [PNW-1:0] p);
    return 16'({p, {IDX_W{1'b0}}});
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      cmdReady <= 1'b0;
      rspValid <= 1'b0;
      rspByte  <= '0;
      dly = 0; busyCnt = 0;
    end else begin
      if (busyCnt != 0) busyCnt--;
      rspValid <= 1'b0;
      if (dly != 0) begin
        dly--;
        if (dly == 0) begin rspValid <= 1'b1; rspByte <= pend; end
      end
      // monitor
      if (wordValid && wordReady) wordsAccepted++;
      if (done) begin doneSeen = 1; doneCycles++; end
      if (rspValid && mLastOp == 8'h4C) begin tracking = 1; gap = 0; end
      else if (tracking) begin
        if (cmdValid) begin gapSeen = gap; tracking = 0; end
        else gap++;
      end
      // command acceptance
      if (cmdValid && cmdReady) begin
        int idx;
        logic [7:0] op;
        op = cmdBytes[31:24];
        idx = int'(cmdBytes[15:8]);
        mLastOp = op;
        pend = 8'h00;
        dly = 2;
        if (busyCnt != 0 && op != 8'hF0) busyViol++;
        case (op)
          8'h40: begin
            if (expectHi || idx != expIdx || cmdBytes[23:16] != 0) ordViol++;
            if (idx < PW) pbLo[idx] = cmdBytes[7:0];
            expectHi = 1; loadCount++;
          end
          8'h48: begin
            if (!expectHi || idx != expIdx || cmdBytes[23:16] != 0) ordViol++;
            if (idx < PW) pbHi[idx] = cmdBytes[7:0];
            expectHi = 0; expIdx++; loadCount++;
          end
          8'h4C: begin
            if (expIdx != PW || expectHi) ordViol++;
            expIdx = 0;
            lastWriteAddr = cmdBytes[23:8];
            for (int k = 0; k < PW; k++)
              flashMem[int'(cmdBytes[23:8]) + k] = {pbHi[k], pbLo[k]} ^ ((k == mCorrupt) ? 16'h0100 : 16'h0000);
            busyCnt = mBusyLen;
            writeCount++;
          end
          8'hF0: begin pend = {7'd0, busyCnt != 0}; pollCount++; end
          8'h20: begin pend = rdFlash(int'(cmdBytes[23:8]))[7:0]; readCount++; end
          8'h28: begin pend = rdFlash(int'(cmdBytes[23:8]))[15:8]; readCount++; end
          default: ordViol++;
        endcase
      end
      cmdReady <= ($urandom_range(2) != 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runPage(input logic [PNW-1:0] page, input bit poll, input bit ver,
                         input int corrupt, input int busyLen, input bit inject);
    int wBefore, lBefore, rBefore, pBefore, i;
    bit injected;
    mBusyLen = busyLen; mCorrupt = corrupt;
    wBefore = writeCount; lBefore = loadCount; rBefore = readCount; pBefore = pollCount;
    wordsAccepted = 0; doneCycles = 0; doneSeen = 0; gapSeen = -1; tracking = 0;
    busyViol = 0; ordViol = 0;
    @(negedge clk);
    pageStart = 1; pageAddr = page; pollMode = poll; verifyEn = ver;
    @(negedge clk);
    pageStart = 0; pollMode = ~poll; verifyEn = ~ver;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    i = 0; injected = 0;
    while (i < PW) begin
      @(negedge clk);
      pageStart = inject && i == 3 && !injected;
      if (pageStart) injected = 1;
      pageAddr  = pageStart ? page ^ 8'h01 : page;
      wordValid = ($urandom_range(3) != 0);
      wordData  = wordValid ? pageData[i] : 16'hDEAD;
      if (wordValid && wordReady) begin @(posedge clk); i++; end
    end
    @(negedge clk);
    wordValid = 0; pageStart = 0;
    while (!doneSeen) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 idle after done", busy, 0);
    chk(doneCycles == 1, "R9 done pulse width", doneCycles, 1);
    chk(wordsAccepted == PW, "R2 words accepted", wordsAccepted, PW);
    chk(ordViol == 0 && loadCount - lBefore == 2 * PW, "R3 load order/count", loadCount - lBefore, 2 * PW);
    chk(writeCount - wBefore == 1, "R4/R9 one write per page", writeCount - wBefore, 1);
    chk(lastWriteAddr == baseAddr(page), "R4 write address", lastWriteAddr, baseAddr(page));
    chk(busyViol == 0, poll ? "R6 no access while busy" : "R5 no access while busy", busyViol, 0);
    if (!poll && ver) chk(gapSeen >= WC, "R5 quiet gap", gapSeen, WC);
    if (poll) chk(pollCount - pBefore >= 2, "R6 polls issued", pollCount - pBefore, 2);
    chk(readCount - rBefore == (ver ? 2 * PW : 0), "R7 read count", readCount - rBefore, ver ? 2 * PW : 0);
    for (int k = 0; k < PW; k++) begin
      logic [15:0] e;
      e = pageData[k] ^ ((k == corrupt) ? 16'h0100 : 16'h0000);
      if (rdFlash(int'(baseAddr(page)) + k) != e)
        chk(0, "R3 stored data", rdFlash(int'(baseAddr(page)) + k), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rstN = 0; pageStart = 0; pageAddr = 0; pollMode = 0; verifyEn = 0;
    wordValid = 0; wordData = 0;
    mBusyLen = 0; mCorrupt = -1; expIdx = 0; expectHi = 0; mLastOp = 0; pend = 0;
    ordViol = 0; busyViol = 0; loadCount = 0; writeCount = 0; readCount = 0; pollCount = 0;
    lastWriteAddr = 0; wordsAccepted = 0; doneCycles = 0; doneSeen = 0; gap = 0; gapSeen = -1; tracking = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
    chk(cmdValid == 0 && wordReady == 0, "R1 handshakes after reset", {cmdValid, wordReady}, 0);
    chk(errFlag == 0 && errAddr == 0, "R1 error state after reset", {errFlag, errAddr}, 0);

    // timed wait with verify, random data
    for (int k = 0; k < PW; k++) pageData[k] = 16'($urandom);
    runPage(8'h12, 0, 1, -1, WC + 4, 0);
    chk(errFlag == 0, "R7 clean verify", errFlag, 0);

    // polling, top page, no verify, stray start in the middle
    for (int k = 0; k < PW; k++) pageData[k] = 16'($urandom);
    runPage(8'hFF, 1, 0, -1, 60, 1);

    // extreme data, page zero, polling with verify
    for (int k = 0; k < PW; k++) pageData[k] = (k % 2 == 0) ? 16'hFFFF : 16'h0000;
    runPage(8'h00, 1, 1, -1, 30, 0);
    chk(errFlag == 0, "R7 clean verify edge data", errFlag, 0);

    // random pages and modes
    for (int n = 0; n < 4; n++) begin
      bit pm;
      pm = 1'($urandom_range(1));
      for (int k = 0; k < PW; k++) pageData[k] = 16'($urandom);
      runPage(8'($urandom), pm, 1, -1, pm ? 45 : WC + 4, 0);
      chk(errFlag == 0, "R7 clean verify random", errFlag, 0);
    end

    // verify mismatch at index 5
    for (int k = 0; k < PW; k++) pageData[k] = 16'($urandom);
    runPage(8'h21, 0, 1, 5, WC + 4, 0);
    chk(errFlag == 1, "R8 mismatch flagged", errFlag, 1);
    chk(errAddr == {8'h21, 3'd5}, "R8 mismatch address", errAddr, {8'h21, 3'd5});

    // second mismatch must not overwrite the first
    for (int k = 0; k < PW; k++) pageData[k] = 16'($urandom);
    runPage(8'h40, 1, 1, 2, 35, 0);
    chk(errFlag == 1, "R8 flag sticky", errFlag, 1);
    chk(errAddr == {8'h21, 3'd5}, "R8 first address kept", errAddr, {8'h21, 3'd5});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule